// File: doc/BRIEF.md
# Calibration Mode Sequencer

This controller runs the calibration conversions of a sigma-delta converter. A host issues a one-cycle request carrying a three-bit mode code and picks one of four calibrations: offset or gain, measured either on an internally generated input or on the voltage present at the external pins. The sequencer first checks the request against the current converter settings and refuses it if it is illegal. For an accepted request it drives the input-select control, marks itself busy and waits a whole number of filter settling periods. It then takes the next averaged result the filter offers.

A zero-scale result goes straight into the offset coefficient register. A full-scale result goes into the gain coefficient register, together with a one-cycle update strobe for the correction datapath. The busy flag drops one cycle after the coefficient write. A refused request changes nothing except a sticky error bit, which the host clears with a write-one pulse. When several channels are enabled, only the lowest-numbered enabled channel is calibrated, and its index is shown on an output while the calibration runs.

Top module: `cal_seq`

## Requirements
- R1: A mode write accepted while idle sets `ready` high in the following cycle. The mode codes are 1 internal zero-scale, 2 internal full-scale, 3 system zero-scale and 4 system full-scale.
- R2: While busy, `in_sel` is 1 (positive input tied to the negative input) for internal zero-scale, 2 (internal full-scale source) for internal full-scale and 0 (external pins) for both system modes. While idle it is 0.
- R3: `res_wait` rises P×S cycles after the cycle in which `ready` first reads high. S is `settle_cycles`, with 0 treated as 1. P is 4 for internal full-scale at a gain code above 0 and 1 for every other mode.
- R4: A `filt_valid` pulse while `res_wait` is high writes `filt_data` into `offset_q` for the zero-scale modes. For the full-scale modes it writes into `gain_q`, and `gain_upd` is high in exactly the cycle in which the new gain first appears.
- R5: `ready` falls one cycle after the coefficient write.
- R6: An internal full-scale request is refused in full-power mode, at gain code 0, or when `offset_q` differs from 0x800000.
- R7: A refused request leaves `offset_q` and `gain_q` unchanged, keeps `ready` low and sets `err` in the next cycle.
- R8: `err` stays set until an `err_clr` pulse. When a refusal and a clear arrive in the same cycle, the refusal wins.
- R9: Mode codes 0, 5, 6 and 7 are refused, and so is any request with no channel enabled.
- R10: While busy, a mode write is ignored. It neither restarts the calibration nor sets `err`.
- R11: While busy, `cal_chan` holds the lowest index set in `chan_en` at the time of the request.
- R12: `filt_valid` pulses that arrive before `res_wait` is high do not change either coefficient.
- R13: After reset, `offset_q` is 0x800000, `gain_q` is 0x555555, and `ready` and `err` are low. An `ofs_rst_wr` pulse while idle restores 0x800000. While busy it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Calibration request strobe |
| mode_val | input | 3 | Requested mode code |
| gain_code | input | 3 | PGA gain as a power of two; 0 means gain 1 |
| full_power | input | 1 | Converter is in full-power mode |
| chan_en | input | NCH | Enabled channel mask |
| settle_cycles | input | CW | Clock cycles per filter settling period |
| err_clr | input | 1 | Write-one pulse clearing `err` |
| ofs_rst_wr | input | 1 | Restore the offset register to 0x800000 |
| filt_valid | input | 1 | Averaged filter result available |
| filt_data | input | DW | Averaged filter result |
| ready | output | 1 | High while a calibration runs |
| err | output | 1 | Sticky refused-request flag |
| in_sel | output | 2 | Input-select control |
| cal_chan | output | CHW | Channel under calibration |
| res_wait | output | 1 | Settling done, waiting for the filter result |
| offset_q | output | DW | Offset coefficient register |
| gain_q | output | DW | Gain coefficient register |
| gain_upd | output | 1 | One-cycle strobe marking a new gain value |

## Verification
A request is applied at a falling edge and takes effect at the next rising edge. `ready`, `in_sel`, `cal_chan` and `err` are therefore checked at the falling edge one cycle later. `res_wait` is checked as still low at the P×S-th falling edge after acceptance and high at the next one. The coefficients and `gain_upd` are checked one cycle after the filter pulse, and the fall of `ready` one cycle after that. Stray filter pulses, busy-time mode writes and offset restores are all applied in the first busy cycle. Their absence of effect shows up in the final coefficient values and in `err`.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    MODE_NONE = 3'd0,
    MODE_IZS  = 3'd1,
    MODE_IFS  = 3'd2,
    MODE_SZS  = 3'd3,
    MODE_SFS  = 3'd4
  } cal_mode_e;

  typedef enum logic [1:0] {
    SEL_PINS  = 2'd0,
    SEL_SHORT = 2'd1,
    SEL_FSREF = 2'd2
  } in_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_WAIT,
    ST_WRAP
  } cal_st_e;
endpackage

// File: rtl/cal_chan_pick.sv
module cal_chan_pick #(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] en,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (en[i]) begin
        any = 1'b1;
        idx = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int CW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] periods,
  input  logic [CW-1:0] settle,
  output logic          done
);
  logic [CW-1:0] cyc_q, cyc_d, lim_q, lim_d;
  logic [PW-1:0] per_q, per_d, plast_q, plast_d;
  logic          run_q, run_d;
  logic          wrap;

  assign wrap = run_q && (cyc_q == lim_q - 1'b1);
  assign done = wrap && (per_q == plast_q);

  always_comb begin
    cyc_d   = cyc_q;
    per_d   = per_q;
    lim_d   = lim_q;
    plast_d = plast_q;
    run_d   = run_q;
    if (start) begin
      cyc_d   = '0;
      per_d   = '0;
      lim_d   = (settle == '0) ? CW'(1) : settle;
      plast_d = periods - 1'b1;
      run_d   = 1'b1;
    end else if (run_q) begin
      if (wrap) begin
        cyc_d = '0;
        per_d = per_q + 1'b1;
        if (done) run_d = 1'b0;
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      per_q   <= '0;
      lim_q   <= CW'(1);
      plast_q <= '0;
      run_q   <= 1'b0;
    end else begin
      cyc_q   <= cyc_d;
      per_q   <= per_d;
      lim_q   <= lim_d;
      plast_q <= plast_d;
      run_q   <= run_d;
    end
  end
endmodule

// File: rtl/cal_coef.sv
module cal_coef #(
  parameter int            DW       = 24,
  parameter logic [DW-1:0] GAIN_DEF = 24'h555555,
  localparam logic [DW-1:0] OFS_DEF = {1'b1, {(DW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ofs_we,
  input  logic          ofs_def_we,
  input  logic          gain_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] offset_q,
  output logic [DW-1:0] gain_q,
  output logic          gain_upd
);
  logic [DW-1:0] ofs_d, gain_d;

  always_comb begin
    ofs_d = offset_q;
    if (ofs_we)          ofs_d = wdata;
    else if (ofs_def_we) ofs_d = OFS_DEF;
    gain_d = gain_we ? wdata : gain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= OFS_DEF;
      gain_q   <= GAIN_DEF;
      gain_upd <= 1'b0;
    end else begin
      offset_q <= ofs_d;
      gain_q   <= gain_d;
      gain_upd <= gain_we;
    end
  end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_pkg::*;
#(
  parameter int            DW       = 24,
  parameter int            CW       = 16,
  parameter int            NCH      = 8,
  parameter logic [DW-1:0] GAIN_DEF = 24'h555555,
  localparam int           CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic [2:0]     mode_val,
  input  logic [2:0]     gain_code,
  input  logic           full_power,
  input  logic [NCH-1:0] chan_en,
  input  logic [CW-1:0]  settle_cycles,
  input  logic           err_clr,
  input  logic           ofs_rst_wr,
  input  logic           filt_valid,
  input  logic [DW-1:0]  filt_data,
  output logic           ready,
  output logic           err,
  output logic [1:0]     in_sel,
  output logic [CHW-1:0] cal_chan,
  output logic           res_wait,
  output logic [DW-1:0]  offset_q,
  output logic [DW-1:0]  gain_q,
  output logic           gain_upd
);
  localparam logic [DW-1:0] OFS_DEF = {1'b1, {(DW-1){1'b0}}};

  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  cal_st_e        st_q, st_d;
  cal_mode_e      mode_q, mode_d;
  logic [1:0]     sel_q, sel_d;
  logic [CHW-1:0] chan_q, chan_d;
  logic           err_q, err_d;

  logic           ch_any;
  logic [CHW-1:0] ch_idx;
  logic           code_ok, ifs_bad, legal, idle, accept, refuse;
  logic           cap, zero_scale, tmr_done;
  logic [2:0]     periods;
  cal_mode_e      req_mode;

  cal_chan_pick #(.NCH(NCH)) i_pick (
    .en  (chan_en),
    .any (ch_any),
    .idx (ch_idx)
  );

  always_comb begin
    req_mode = cal_mode_e'(mode_val);
    code_ok  = (mode_val >= 3'd1) && (mode_val <= 3'd4);
    ifs_bad  = (req_mode == MODE_IFS) &&
               (full_power || (gain_code == 3'd0) || (offset_q != OFS_DEF));
    legal    = code_ok && ch_any && !ifs_bad;
    idle     = (st_q == ST_IDLE);
    accept   = mode_wr && idle && legal;
    refuse   = mode_wr && idle && !legal;
    periods  = ((req_mode == MODE_IFS) && (gain_code != 3'd0)) ? 3'd4 : 3'd1;
    cap        = (st_q == ST_WAIT) && filt_valid;
    zero_scale = (mode_q == MODE_IZS) || (mode_q == MODE_SZS);
  end

  cal_timer #(.CW(CW), .PW(3)) i_timer (
    .clk     (clk),
    .rst_n   (rs_n),
    .start   (accept),
    .periods (periods),
    .settle  (settle_cycles),
    .done    (tmr_done)
  );

  cal_coef #(.DW(DW), .GAIN_DEF(GAIN_DEF)) i_coef (
    .clk        (clk),
    .rst_n      (rs_n),
    .ofs_we     (cap && zero_scale),
    .ofs_def_we (ofs_rst_wr && idle),
    .gain_we    (cap && !zero_scale),
    .wdata      (filt_data),
    .offset_q   (offset_q),
    .gain_q     (gain_q),
    .gain_upd   (gain_upd)
  );

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    sel_d  = sel_q;
    chan_d = chan_q;
    err_d  = err_q;
    if (err_clr) err_d = 1'b0;
    if (refuse)  err_d = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_SETTLE;
          mode_d = req_mode;
          chan_d = ch_idx;
          unique case (req_mode)
            MODE_IZS: sel_d = SEL_SHORT;
            MODE_IFS: sel_d = SEL_FSREF;
            default:  sel_d = SEL_PINS;
          endcase
        end
      end
      ST_SETTLE: if (tmr_done) st_d = ST_WAIT;
      ST_WAIT:   if (cap)      st_d = ST_WRAP;
      ST_WRAP: begin
        st_d  = ST_IDLE;
        sel_d = SEL_PINS;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_NONE;
      sel_q  <= SEL_PINS;
      chan_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      sel_q  <= sel_d;
      chan_q <= chan_d;
      err_q  <= err_d;
    end
  end

  assign ready    = (st_q != ST_IDLE);
  assign res_wait = (st_q == ST_WAIT);
  assign in_sel   = sel_q;
  assign cal_chan = chan_q;
  assign err      = err_q;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
  parameter int DW  = 24,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           err,
  input logic [1:0]     in_sel,
  input logic [CHW-1:0] cal_chan,
  input logic           res_wait,
  input logic [DW-1:0]  offset_q,
  input logic [DW-1:0]  gain_q,
  input logic           gain_upd
);
  a_r2_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (in_sel == 2'd0));

  a_r11_hold_sel_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> ($stable(in_sel) && $stable(cal_chan)));

  a_r3_wait_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_wait |-> ready);

  a_r4_gain_changes_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_q) |-> gain_upd);

  a_r4_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    gain_upd |-> (ready && !res_wait));

  a_r5_ready_falls_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(res_wait, 2));

  a_r7_refuse_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !ready);

  a_r13_offset_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_q) |-> ($past(res_wait) || !$past(ready)));
endmodule

bind cal_seq cal_seq_chk #(.DW(DW), .CHW(CHW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .err      (err),
  .in_sel   (in_sel),
  .cal_chan (cal_chan),
  .res_wait (res_wait),
  .offset_q (offset_q),
  .gain_q   (gain_q),
  .gain_upd (gain_upd)
);

// File: tb/test_cal_seq.sv
`timescale 1ns/1ps
module test_cal_seq;
  localparam int DW = 24, CW = 16, NCH = 8, CHW = 3;
  localparam logic [23:0] OFS0 = 24'h800000, GAIN0 = 24'h555555;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 0, full_power = 0, err_clr = 0, ofs_rst_wr = 0, filt_valid = 0;
  logic [2:0] mode_val = 0, gain_code = 0;
  logic [NCH-1:0] chan_en = 0;
  logic [CW-1:0] settle_cycles = 0;
  logic [DW-1:0] filt_data = 0;
  logic ready, err, res_wait, gain_upd;
  logic [1:0] in_sel;
  logic [CHW-1:0] cal_chan;
  logic [DW-1:0] offset_q, gain_q;

  int checks = 0, errors = 0;
  logic [23:0] m_ofs = OFS0, m_gain = GAIN0;

  always #2 clk = ~clk;

  cal_seq i_cal_seq (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic is_legal(input [2:0] m, input [2:0] g, input fp, input [7:0] en, input [23:0] ofs);
    if (m < 3'd1 || m > 3'd4 || en == 8'd0) return 1'b0;
    if (m == 3'd2 && (fp || g == 3'd0 || ofs != OFS0)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int first_chan(input [7:0] en);
    for (int i = 0; i < 8; i++) if (en[i]) return i;
    return 0;
  endfunction

  function automatic logic [1:0] exp_sel(input [2:0] m);
    return (m == 3'd1) ? 2'd1 : (m == 3'd2) ? 2'd2 : 2'd0;
  endfunction

  task automatic run_req(input [2:0] m, input [2:0] g, input fp, input [7:0] en,
                         input [15:0] s, input [23:0] d, input logic clr_same);
    logic lg;
    int n, k;
    lg = is_legal(m, g, fp, en, m_ofs);
    n  = ((m == 3'd2 && g != 0) ? 4 : 1) * ((s == 0) ? 1 : int'(s));
    @(negedge clk);
    mode_val = m; mode_wr = 1; gain_code = g; full_power = fp;
    chan_en = en; settle_cycles = s; err_clr = clr_same;
    @(negedge clk);
    mode_wr = 0; err_clr = 0;
    if (!lg) begin
      chk(ready == 0, "R7 ready low on refusal", 32'(ready), 0);
      chk(err == 1, "R6/R9 refusal sets err", 32'(err), 1);
      chk(offset_q == m_ofs && gain_q == m_gain, "R7 coefficients kept",
          32'(offset_q ^ gain_q), 32'(m_ofs ^ m_gain));
      err_clr = 1;
      @(negedge clk);
      err_clr = 0;
      chk(err == 0, "R8 err cleared", 32'(err), 0);
      return;
    end
    chk(ready == 1, "R1 ready after accept", 32'(ready), 1);
    chk(in_sel == exp_sel(m), "R2 input select", 32'(in_sel), 32'(exp_sel(m)));
    chk(int'(cal_chan) == first_chan(en), "R11 first channel", 32'(cal_chan), 32'(first_chan(en)));
    // busy-time disturbances (R10, R12, R13)
    mode_wr = 1; mode_val = 3'd1; filt_valid = 1; filt_data = ~d; ofs_rst_wr = 1;
    @(negedge clk);
    mode_wr = 0; filt_valid = 0; ofs_rst_wr = 0;
    k = 2;
    while (k < n) begin @(negedge clk); k++; end
    if (k == n) begin
      chk(res_wait == 0, "R3 still settling", 32'(res_wait), 0);
      @(negedge clk); k++;
    end
    chk(res_wait == 1, "R3 settling length", 32'(res_wait), 1);
    chk(err == 0, "R10 busy write no err", 32'(err), 0);
    filt_valid = 1; filt_data = d;
    @(negedge clk);
    filt_valid = 0;
    if (m == 3'd1 || m == 3'd3) m_ofs = d; else m_gain = d;
    chk(offset_q == m_ofs, "R4/R12/R13 offset value", 32'(offset_q), 32'(m_ofs));
    chk(gain_q == m_gain, "R4/R12 gain value", 32'(gain_q), 32'(m_gain));
    chk(gain_upd == (m == 3'd2 || m == 3'd4), "R4 gain strobe", 32'(gain_upd), 32'(m == 3'd2 || m == 3'd4));
    chk(ready == 1, "R5 ready held on write", 32'(ready), 1);
    @(negedge clk);
    chk(ready == 0, "R5 ready falls", 32'(ready), 0);
    chk(gain_upd == 0, "R4 strobe one cycle", 32'(gain_upd), 0);
    chk(in_sel == 2'd0, "R2 idle pins", 32'(in_sel), 0);
  endtask

  task automatic restore_ofs();
    @(negedge clk); ofs_rst_wr = 1;
    @(negedge clk); ofs_rst_wr = 0;
    m_ofs = OFS0;
    chk(offset_q == OFS0, "R13 restore while idle", 32'(offset_q), 32'(OFS0));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(offset_q == OFS0, "R13 reset offset", 32'(offset_q), 32'(OFS0));
    chk(gain_q == GAIN0, "R13 reset gain", 32'(gain_q), 32'(GAIN0));
    chk(ready == 0 && err == 0, "R13 reset flags", 32'({ready, err}), 0);

    run_req(3'd2, 3'd3, 0, 8'b0001_0100, 16'd3, 24'h5a0001, 0); // R3 four periods
    run_req(3'd1, 3'd1, 0, 8'b1010_0000, 16'd2, 24'h123456, 0); // R1 R2 R11
    run_req(3'd2, 3'd3, 0, 8'h01, 16'd2, 24'h0, 0);             // R6 offset not default
    restore_ofs();                                               // R13
    run_req(3'd2, 3'd2, 1, 8'h01, 16'd2, 24'h0, 0);             // R6 full power
    run_req(3'd2, 3'd0, 0, 8'h01, 16'd2, 24'h0, 0);             // R6 gain 1
    run_req(3'd0, 3'd2, 0, 8'h01, 16'd2, 24'h0, 0);             // R9 code 0
    run_req(3'd7, 3'd2, 0, 8'h01, 16'd2, 24'h0, 0);             // R9 code 7
    run_req(3'd3, 3'd2, 0, 8'h00, 16'd2, 24'h0, 0);             // R9 no channel
    run_req(3'd4, 3'd5, 0, 8'h80, 16'd0, 24'habcdef, 0);        // R3 settle 0
    run_req(3'd2, 3'd2, 0, 8'h02, 16'd1, 24'h654321, 0);        // R3 gain>1 short
    // R8: refusal and clear in the same cycle -> set wins
    @(negedge clk); mode_val = 3'd6; mode_wr = 1; chan_en = 8'h01; err_clr = 1;
    @(negedge clk); mode_wr = 0; err_clr = 0;
    chk(err == 1, "R8 set wins over clear", 32'(err), 1);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk(err == 0, "R8 clear", 32'(err), 0);

    for (int it = 0; it < 80; it++) begin
      logic [2:0] m, g;
      logic fp;
      logic [7:0] en;
      if ($urandom % 3 == 0) restore_ofs();
      m  = 3'($urandom % 6);
      g  = 3'($urandom % 8);
      fp = ($urandom % 4 == 0);
      en = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
      run_req(m, g, fp, en, 16'($urandom % 5), 24'($urandom), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule